// File: doc/BRIEF.md
# EPP Parallel Port Controller

This block is the host side of a parallel port. A byte-wide register window of eight offsets gives the host the usual data, status and control registers. Two further offsets each run one handshaked Enhanced Parallel Port bus cycle on the peripheral side: one runs an address cycle and one runs a data cycle. Software first sets the control register to the pattern for the direction it wants, then reads or writes the address or data offset. The controller pulses the matching strobe, waits for the peripheral's wait line, and returns.

The data offset also takes 2-byte and 4-byte host accesses. These are split into consecutive byte cycles, lowest byte first. If a peripheral does not answer within a programmable number of clocks, the cycle is abandoned and a sticky timeout flag in the status register is set. While a bus cycle is in progress the host sees `host_busy` high. Every access, whether a register or a bus cycle, ends with a one-cycle `host_done` pulse that carries the read data.

Top module: `epp_port_ctrl`

## Requirements
- R1: Offsets are 0 data, 1 status, 2 control, 3 EPP address, 4 EPP data. Reads at offsets 5 to 7 return 0xFF and writes there have no effect. Byte reads are zero-extended to 32 bits.
- R2: After reset the data register reads 0xFF, the control register reads 0xCC, the timeout flag (status bit 0) is 0 and `pd_oe` is 1.
- R3: A control write stores bits 5:0 of the written byte and forces bits 7:6 to 1. `ctl_out` carries control bits 3:0 and `pd_oe` is the inverse of control bit 5 (direction).
- R4: With direction 0, a data read returns the last byte written to offset 0. With direction 1, it returns `pd_in` as sampled in the request cycle.
- R5: An EPP write at offset 3 or 4 runs a bus cycle only when control bits {5,3,2,1,0} equal 00100. Otherwise it starts no strobe and completes one cycle after the request.
- R6: An EPP read runs only when control bits {5,3,2,1,0} equal 10100. Otherwise no strobe occurs and the read returns all ones across the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R7: Offset 3 cycles drive `addr_stb_n` low and offset 4 cycles drive `data_stb_n` low, never both together. During a write cycle `write_n` is low and `pd_out` carries the byte. A read cycle captures `pd_in` in the clock in which `wait_in` is seen high.
- R8: `host_size` 0, 1 and 2 give 1, 2 and 4 bytes at offset 4, and byte i of the host word is transferred in cycle i. At every other offset the size is ignored and the access is a byte.
- R9: If `wait_in` is not seen high within `tmo_limit` clocks of a strobe, the access ends, status bit 0 becomes 1, and any remaining bytes are skipped; bytes not read return 0xFF. Done arrives `tmo_limit`+1 cycles after the request.
- R10: Writing status with bit 0 set clears the timeout flag. Writing it with bit 0 clear leaves the flag as it was.
- R11: A register access, or a bus cycle that is gated off, gives `host_done` one cycle after the request with `host_busy` low. A bus cycle holds `host_busy` high from the cycle after the request until its done pulse. A successful single-byte cycle with peripheral delay D completes D+3 cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when host_busy is low |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | 0 byte, 1 two bytes, 2 four bytes (offset 4 only) |
| host_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| host_rdata | output | 32 | Read data, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Bus cycle in progress |
| tmo_limit | input | 16 | Clocks to wait for the peripheral |
| pd_out | output | 8 | Data lines driven toward the peripheral |
| pd_oe | output | 1 | Data line output enable |
| pd_in | input | 8 | Data lines as seen at the pins |
| ctl_out | output | 4 | Control signal bits 3:0 |
| stat_in | input | 5 | Peripheral status lines, read as status bits 7:3 |
| write_n | output | 1 | Low during an EPP write cycle |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| wait_in | input | 1 | Peripheral handshake, high when serviced |

## Verification
Register accesses and gated-off bus cycles must show done exactly one cycle after the request. The bench samples at the falling edge and counts falling edges from the request edge, so it expects a latency of 1 for these. A one-byte cycle with a peripheral delay of D finishes after D+3 cycles, and a timed-out cycle after `tmo_limit`+1. The bench checks both numbers, including the boundary where D+2 equals the limit, and one step past it. Read data, logged peripheral-side write bytes and strobe counts are compared only after done. Status and control effects are read back through the register window in a following access.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;
  localparam logic [2:0] OFS_EDAT = 3'd4;

  // control bits {dir, selin, init, autofd, strobe} for a legal cycle
  localparam logic [4:0] GATE_WR = 5'b00100;
  localparam logic [4:0] GATE_RD = 5'b10100;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STROBE, SQ_GAP, SQ_DONE} seq_state_t;

  function automatic int unsigned lanes_for(input logic [1:0] sz, input int unsigned nb);
    int unsigned n;
    n = 1 << sz;
    return (n > nb) ? nb : n;
  endfunction
endpackage

// File: rtl/epp_regs.sv
module epp_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          tmo_set,
  input  logic [DW-1:0] pd_in,
  input  logic [4:0]    stat_in,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] data_q,
  output logic          tmo_q,
  output logic [DW-1:0] rd_val
);
  import epp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '1;
      ctrl_q <= 8'hCC;
      tmo_q  <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_DATA) data_q <= wdata;
      if (wr_en && addr == OFS_CTRL) ctrl_q <= {2'b11, wdata[5:0]};
      if (tmo_set) tmo_q <= 1'b1;
      else if (wr_en && addr == OFS_STAT && wdata[0]) tmo_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFS_DATA: rd_val = ctrl_q[5] ? pd_in : data_q;
      OFS_STAT: rd_val = {stat_in, 2'b11, tmo_q};
      OFS_CTRL: rd_val = ctrl_q;
      default:  rd_val = '1;
    endcase
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CTRL) |=> ctrl_q == {2'b11, $past(wdata[5:0])}); // R3
  AST_TMO_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_q) |-> $past(tmo_set)); // R9
  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_STAT && wdata[0] && !tmo_set) |=> !tmo_q); // R10
endmodule

// File: rtl/epp_seq.sv
module epp_seq #(
  parameter int DW    = 8,
  parameter int NB    = 4,
  parameter int TMO_W = 16,
  localparam int NBW  = $clog2(NB + 1),
  localparam int IW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_read,
  input  logic             is_addr,
  input  logic [NBW-1:0]   nbytes,
  input  logic [NB*DW-1:0] wdata,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             wait_in,
  input  logic [DW-1:0]    pd_in,
  output logic             busy,
  output logic             done,
  output logic             tmo_hit,
  output logic [NB*DW-1:0] rdata,
  output logic [DW-1:0]    pd_drv,
  output logic             write_n,
  output logic             addr_stb_n,
  output logic             data_stb_n
);
  import epp_pkg::*;

  seq_state_t       st;
  logic [TMO_W-1:0] cnt;
  logic [IW-1:0]    idx, last;
  logic             rd_q, ad_q;
  logic [NB*DW-1:0] wbuf;
  logic             expired;

  assign expired = ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_limit};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      idx     <= '0;
      last    <= '0;
      rd_q    <= 1'b0;
      ad_q    <= 1'b0;
      wbuf    <= '0;
      rdata   <= '0;
      tmo_hit <= 1'b0;
    end else begin
      tmo_hit <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          st   <= SQ_STROBE;
          cnt  <= '0;
          idx  <= '0;
          last <= IW'(nbytes - 1'b1);
          rd_q <= is_read;
          ad_q <= is_addr;
          wbuf <= wdata;
          for (int i = 0; i < NB; i++)
            rdata[i*DW +: DW] <= (NBW'(i) < nbytes) ? {DW{1'b1}} : {DW{1'b0}};
        end
        SQ_STROBE: if (wait_in) begin
          if (rd_q) rdata[idx*DW +: DW] <= pd_in;
          cnt <= '0;
          if (idx == last) st <= SQ_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= SQ_GAP;
          end
        end else if (expired) begin
          tmo_hit <= 1'b1;
          st      <= SQ_DONE;
        end else cnt <= cnt + 1'b1;
        SQ_GAP: if (!wait_in) begin
          st  <= SQ_STROBE;
          cnt <= '0;
        end else if (expired) begin
          tmo_hit <= 1'b1;
          st      <= SQ_DONE;
        end else cnt <= cnt + 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (st != SQ_IDLE);
  assign done       = (st == SQ_DONE);
  assign pd_drv     = wbuf[idx*DW +: DW];
  assign write_n    = !((st == SQ_STROBE || st == SQ_GAP) && !rd_q);
  assign addr_stb_n = !(st == SQ_STROBE && ad_q);
  assign data_stb_n = !(st == SQ_STROBE && !ad_q);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!addr_stb_n && !data_stb_n)); // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
endmodule

// File: rtl/epp_port_ctrl.sv
module epp_port_ctrl #(
  parameter int DW    = 8,
  parameter int HW    = 32,
  parameter int TMO_W = 16,
  localparam int NB   = HW / DW,
  localparam int NBW  = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [1:0]       host_size,
  input  logic [HW-1:0]    host_wdata,
  output logic [HW-1:0]    host_rdata,
  output logic             host_done,
  output logic             host_busy,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [DW-1:0]    pd_out,
  output logic             pd_oe,
  input  logic [DW-1:0]    pd_in,
  output logic [3:0]       ctl_out,
  input  logic [4:0]       stat_in,
  output logic             write_n,
  output logic             addr_stb_n,
  output logic             data_stb_n,
  input  logic             wait_in
);
  import epp_pkg::*;

  logic [DW-1:0]  ctrl_q, data_q, rd_val, seq_pd;
  logic           tmo_q, seq_busy, seq_done, seq_tmo;
  logic [HW-1:0]  seq_rdata, rdata_q, ones_mask;
  logic [NBW-1:0] nbytes;
  logic           accept, is_epp, gate_ok, epp_go, reg_path, reg_done_q;
  logic [4:0]     gate_bits;

  assign gate_bits = {ctrl_q[5], ctrl_q[3:0]};
  assign is_epp    = (host_addr == OFS_EADR) || (host_addr == OFS_EDAT);
  assign gate_ok   = host_we ? (gate_bits == GATE_WR) : (gate_bits == GATE_RD);
  assign accept    = host_req && !seq_busy;
  assign epp_go    = accept && is_epp && gate_ok;
  assign reg_path  = accept && !epp_go;
  assign nbytes    = (host_addr == OFS_EDAT) ? NBW'(lanes_for(host_size, NB)) : NBW'(1);

  always_comb begin
    for (int i = 0; i < NB; i++)
      ones_mask[i*DW +: DW] = (NBW'(i) < nbytes) ? {DW{1'b1}} : {DW{1'b0}};
  end

  epp_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_path && host_we && !is_epp),
    .addr(host_addr), .wdata(host_wdata[DW-1:0]),
    .tmo_set(seq_tmo), .pd_in(pd_in), .stat_in(stat_in),
    .ctrl_q(ctrl_q), .data_q(data_q), .tmo_q(tmo_q), .rd_val(rd_val)
  );

  epp_seq #(.DW(DW), .NB(NB), .TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst(rst), .start(epp_go),
    .is_read(!host_we), .is_addr(host_addr == OFS_EADR),
    .nbytes(nbytes), .wdata(host_wdata), .tmo_limit(tmo_limit),
    .wait_in(wait_in), .pd_in(pd_in),
    .busy(seq_busy), .done(seq_done), .tmo_hit(seq_tmo), .rdata(seq_rdata),
    .pd_drv(seq_pd), .write_n(write_n),
    .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_done_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      reg_done_q <= reg_path;
      if (reg_path) rdata_q <= is_epp ? ones_mask : {{(HW-DW){1'b0}}, rd_val};
    end
  end

  assign host_done  = reg_done_q | seq_done;
  assign host_rdata = seq_done ? seq_rdata : rdata_q;
  assign host_busy  = seq_busy;
  assign pd_out     = write_n ? data_q : seq_pd;
  assign pd_oe      = !ctrl_q[5];
  assign ctl_out    = ctrl_q[3:0];

  AST_EPP_GATED: assert property (@(posedge clk) disable iff (rst)
    (!addr_stb_n || !data_stb_n) |-> (gate_bits == (write_n ? GATE_RD : GATE_WR))); // R5
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !write_n |-> pd_oe); // R7
  AST_REG_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    reg_done_q |-> !seq_done); // R11
endmodule

// File: tb/epp_port_ctrl_tb.sv
module epp_port_ctrl_tb;
  localparam int LIM = 8;

  logic        clk = 1'b0, rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        host_done, host_busy;
  logic [15:0] tmo_limit = 16'(LIM);
  logic [7:0]  pd_out, pd_in;
  logic        pd_oe, write_n, addr_stb_n, data_stb_n, wait_in;
  logic [3:0]  ctl_out;
  logic [4:0]  stat_in = 5'b10110;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // peripheral model state
  bit   per_en = 1;
  int   per_dly = 1, dcnt, rd_ptr, wr_cnt, stb_cnt;
  logic served, served_rd, prev_stb;
  logic [8:0] wr_log [0:255];
  logic stb_low;

  always #5 clk = ~clk;

  epp_port_ctrl u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_done(host_done), .host_busy(host_busy),
    .tmo_limit(tmo_limit), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .ctl_out(ctl_out), .stat_in(stat_in), .write_n(write_n),
    .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .wait_in(wait_in)
  );

  function automatic logic [7:0] pat(input int n);
    return 8'h5A + 8'(n) * 8'd37;
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 1);
  endfunction

  assign stb_low = !addr_stb_n || !data_stb_n;
  assign pd_in   = pat(rd_ptr);

  always @(posedge clk) begin
    if (rst) begin
      wait_in <= 1'b0; dcnt <= 0; rd_ptr <= 0; wr_cnt <= 0; stb_cnt <= 0;
      served <= 1'b0; served_rd <= 1'b0; prev_stb <= 1'b0;
    end else begin
      prev_stb <= stb_low;
      if (stb_low && !prev_stb) stb_cnt <= stb_cnt + 1;
      if (stb_low) begin
        if (per_en && !served) begin
          if (dcnt >= per_dly) begin
            wait_in <= 1'b1; served <= 1'b1; served_rd <= write_n;
            if (!write_n) begin
              wr_log[wr_cnt[7:0]] <= {!addr_stb_n, pd_out};
              wr_cnt <= wr_cnt + 1;
            end
          end else dcnt <= dcnt + 1;
        end
      end else begin
        wait_in <= 1'b0; dcnt <= 0;
        if (served && served_rd) rd_ptr <= rd_ptr + 1;
        served <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat,
                     output bit busy1);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
    @(posedge clk);
    #1 host_req = 1'b0;
    lat = 0; busy1 = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) busy1 = host_busy;
    end while (!host_done && lat < 1000);
    rd = host_rdata;
  endtask

  task automatic wr8(input logic [2:0] a, input logic [7:0] v);
    logic [31:0] r; int l; bit b;
    acc(1'b1, a, 2'd0, {24'h0, v}, r, l, b);
  endtask

  task automatic rd8(input logic [2:0] a, output logic [31:0] r);
    int l; bit b;
    acc(1'b0, a, 2'd0, 32'h0, r, l, b);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, exp;
    int lat, w0, s0, p0, nb;
    bit b1;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R2 reset state
    chk(pd_oe === 1'b1 && ctl_out === 4'hC, "R2 pins", {27'h0, pd_oe, ctl_out}, 32'h1C);
    acc(1'b0, 3'd2, 2'd0, 0, r, lat, b1);
    chk(r === 32'hCC, "R2 control", r, 32'hCC);
    chk(lat == 1 && !b1, "R11 reg latency", lat, 1);
    rd8(3'd0, r); chk(r === 32'hFF, "R2 data", r, 32'hFF);
    rd8(3'd1, r); chk(r === {24'h0, stat_in, 3'b110}, "R2 status", r, {24'h0, stat_in, 3'b110});

    // R3 control write forces top bits
    wr8(3'd2, 8'h00); rd8(3'd2, r); chk(r === 32'hC0, "R3 top bits", r, 32'hC0);
    chk(ctl_out === 4'h0 && pd_oe === 1'b1, "R3 pins", {27'h0, pd_oe, ctl_out}, 32'h10);
    wr8(3'd2, 8'h2B); rd8(3'd2, r); chk(r === 32'hEB, "R3 readback", r, 32'hEB);
    chk(ctl_out === 4'hB && pd_oe === 1'b0, "R3 dir", {27'h0, pd_oe, ctl_out}, 32'h0B);

    // R4 data register in both directions, R8 size ignored at offset 0
    wr8(3'd2, 8'h0C);
    acc(1'b1, 3'd0, 2'd2, 32'h11223344, r, lat, b1);
    rd8(3'd0, r); chk(r === 32'h44, "R4 R8 dir0 data", r, 32'h44);
    chk(pd_out === 8'h44, "R4 pd_out", pd_out, 32'h44);
    wr8(3'd2, 8'h20); rd8(3'd0, r); chk(r === {24'h0, pd_in}, "R4 dir1 pins", r, {24'h0, pd_in});

    // R1 unused offsets
    rd8(3'd6, r); chk(r === 32'hFF, "R1 offset6", r, 32'hFF);
    wr8(3'd7, 8'h00); rd8(3'd2, r); chk(r === 32'hE0, "R1 ignored write", r, 32'hE0);

    // R5 gated-off write: control 0xCC has select-in set
    wr8(3'd2, 8'hCC);
    w0 = wr_cnt; s0 = stb_cnt;
    acc(1'b1, 3'd4, 2'd2, 32'hDEADBEEF, r, lat, b1);
    repeat (3) @(negedge clk);
    chk(stb_cnt == s0 && wr_cnt == w0 && lat == 1, "R5 gated write", stb_cnt - s0, 0);

    // R6 gated-off read with direction 0
    wr8(3'd2, 8'h04);
    acc(1'b0, 3'd4, 2'd1, 0, r, lat, b1);
    chk(r === 32'h0000FFFF && stb_cnt == s0, "R6 gated read", r, 32'h0000FFFF);

    // R7 address write, R11 busy
    per_dly = 1; w0 = wr_cnt;
    acc(1'b1, 3'd3, 2'd0, 32'h000000A5, r, lat, b1);
    chk(b1 && wr_cnt == w0 + 1 && wr_log[w0[7:0]] === {1'b1, 8'hA5}, "R7 R11 addr write",
        {23'h0, wr_log[w0[7:0]]}, 32'h1A5);

    // R8 wide write, little-endian order
    w0 = wr_cnt;
    acc(1'b1, 3'd4, 2'd2, 32'h44332211, r, lat, b1);
    exp = 32'h44332211;
    for (int i = 0; i < 4; i++)
      chk(wr_log[8'(w0 + i)] === {1'b0, exp[8*i +: 8]}, "R8 wide write lane",
          {23'h0, wr_log[8'(w0 + i)]}, {23'h0, 1'b0, exp[8*i +: 8]});

    // R11 latency boundary: delay 6, limit 8
    wr8(3'd2, 8'h24);
    per_dly = 6; p0 = rd_ptr;
    acc(1'b0, 3'd4, 2'd0, 0, r, lat, b1);
    chk(r === {24'h0, pat(p0)} && lat == 9, "R11 R7 slow read", r, {24'h0, pat(p0)});
    rd8(3'd1, r); chk(r[0] === 1'b0, "R9 no timeout at boundary", r, {r[31:1], 1'b0});

    // R9 one clock too slow
    per_dly = 7;
    acc(1'b0, 3'd4, 2'd0, 0, r, lat, b1);
    chk(r === 32'hFF && lat == LIM + 1, "R9 late peripheral", r, 32'hFF);
    wr8(3'd1, 8'h01);

    // R9 wide read, silent peripheral
    per_en = 0; per_dly = 1; s0 = stb_cnt;
    acc(1'b0, 3'd4, 2'd2, 0, r, lat, b1);
    repeat (2) @(negedge clk);
    chk(r === 32'hFFFFFFFF && lat == LIM + 1 && stb_cnt == s0 + 1, "R9 timeout", r, 32'hFFFFFFFF);
    rd8(3'd1, r); chk(r[0] === 1'b1, "R9 flag set", r, {r[31:1], 1'b1});
    wr8(3'd1, 8'hFE); rd8(3'd1, r); chk(r[0] === 1'b1, "R10 bit0 clear keeps", r, {r[31:1], 1'b1});
    wr8(3'd1, 8'h01); rd8(3'd1, r); chk(r[0] === 1'b0, "R10 clear", r, {r[31:1], 1'b0});
    per_en = 1;

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      logic [31:0] wd;
      logic [1:0] sz;
      op = int'($urandom % 4);
      sz = 2'($urandom % 3);
      wd = $urandom;
      per_dly = int'($urandom % 4);
      nb = (op == 0 || op == 2) ? (1 << sz) : 1;
      if (op < 2) begin
        wr8(3'd2, 8'h04);
        w0 = wr_cnt;
        acc(1'b1, (op == 1) ? 3'd3 : 3'd4, sz, wd, r, lat, b1);
        for (int i = 0; i < nb; i++)
          chk(wr_log[8'(w0 + i)] === {(op == 1), wd[8*i +: 8]}, "R7 R8 random write",
              {23'h0, wr_log[8'(w0 + i)]}, {23'h0, (op == 1), wd[8*i +: 8]});
      end else begin
        wr8(3'd2, 8'h24);
        p0 = rd_ptr;
        acc(1'b0, (op == 3) ? 3'd3 : 3'd4, sz, 0, r, lat, b1);
        exp = mask_of(nb);
        for (int i = 0; i < nb; i++) exp[8*i +: 8] = pat(p0 + i);
        chk(r === exp && b1, "R7 R8 random read", r, exp);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule